// File: doc/BRIEF.md
# DDR PSRAM Transaction Phase Sequencer

This block runs one transaction at a time on a double-data-rate pseudo-static RAM bus. A host raises a start strobe together with a 16-bit command code, a 32-bit address, a dummy length in bit-times, a direction flag, a data length in bits and, for writes, the write payload. The sequencer then walks a fixed chain of phases: chip-select setup, command, address, an optional dummy gap, optional data, chip-select hold, and a short deselected gap before it will take the next request. It presents one transaction at a time and has no queue.

The bus is modelled at the cycle level. Each clock cycle carries two beats: one launched on the rising edge and one on the falling edge. Each beat has its own 16-bit output lane and its own 16-bit input lane. Command, address and dummy always use the low 8 lines. Data uses all 16 lines in wide mode or the low 8 lines in narrow mode. The width is taken from a configuration input at the moment a request is accepted. Read data is packed without any byte swapping into a result register that the host reads once the done pulse has appeared.

Top module: `psram_phase_seq`

## Requirements
- R1: After reset, `mem_cs_n` is 1, `busy`, `done` and `mem_dq_oe` are 0, and `rd_data` is all zeros.
- R2: A start seen while idle is accepted at that clock edge. For the next 4 cycles `mem_cs_n` is 0 and `mem_dq_oe` is 0 (setup).
- R3: The single command cycle follows with `mem_dq_oe` = 1. Command bits 15:8 appear on rising lanes 7:0 and bits 7:0 appear on falling lanes 7:0. Lanes 15:8 carry 0.
- R4: Two address cycles follow with `mem_dq_oe` = 1, most significant byte first. Cycle 0 carries address bits 31:24 on the rise lanes and 23:16 on the fall lanes. Cycle 1 carries bits 15:8 and 7:0. All of these use lanes 7:0.
- R5: The dummy phase lasts ceil(dummy_bits/16) cycles and is skipped when that is 0. During a write it drives zeros with `mem_dq_oe` = 1. During a read `mem_dq_oe` is 0.
- R6: The data phase lasts ceil(min(data_bits,128)/(2·L)) cycles, where L is 16 in wide mode and 8 in narrow mode, and it is skipped when that is 0. In data cycle j, the rising beat carries payload bits [2j·L, 2j·L+L) and the falling beat carries bits [(2j+1)·L, (2j+2)·L), each on lanes L-1:0. Bit positions at 128 or above read as 0, and lanes at L or above are 0. Writes drive these beats with `mem_dq_oe` = 1. Reads keep `mem_dq_oe` at 0.
- R7: For a read, the input beats of each data cycle are stored into `rd_data` at the same positions as in R6. Input lanes at L or above are ignored. Bits beyond the transferred beats are 0. `rd_data` is cleared when a request is accepted, so it reads all zeros after a write.
- R8: After the data phase, `mem_cs_n` stays 0 for 4 hold cycles with `mem_dq_oe` = 0. Then 3 gap cycles follow with `mem_cs_n` = 1. `busy` is 1 from the first setup cycle through the last gap cycle.
- R9: `done` is 1 for exactly one cycle, the first cycle after the gap, and `busy` is 0 in that cycle.
- R10: A start, or any change of the request inputs, while `busy` is 1 has no effect on the running transaction.
- R11: `cfg_wide` is sampled only when a request is accepted. Changing it during a transaction does not alter the bus or the returned data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Request strobe, taken when not busy |
| req_cmd | input | 16 | Command code, sent high byte first |
| req_addr | input | 32 | Transaction address |
| req_dummy_bits | input | 8 | Dummy length in bit-times |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data_bits | input | 8 | Data length in bits, clamped to 128 |
| req_wdata | input | 128 | Write payload, bit 0 goes out first |
| cfg_wide | input | 1 | 1 = 16 data lines, 0 = 8 data lines |
| busy | output | 1 | Transaction in progress, including the gap |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 128 | Assembled read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_dq_oe | output | 1 | Output enable of the data lines |
| mem_dq_rise | output | 16 | Beat launched on the rising edge |
| mem_dq_fall | output | 16 | Beat launched on the falling edge |
| mem_dq_in_rise | input | 16 | Beat captured from the rising edge |
| mem_dq_in_fall | input | 16 | Beat captured from the falling edge |

## Verification
Assertions check several properties on every cycle. The done pulse lasts one cycle and never coincides with `busy`. A transaction can start only from idle. The latched width stays steady while busy. The output enable is never high while chip-select is released, and it is never high during read dummy or read data cycles. Result data stays unchanged outside read data cycles. Other behaviours depend on the contents of a transaction, so only the bench's scenarios can show them. These are the exact phase lengths for each dummy and data size, the byte order of command, address and payload on each edge, the packing of read beats in both widths, and the fact that strobes and width changes made mid-transaction are ignored.

// File: rtl/psq_pkg.sv
package psq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_CMD   = 3'd2,
    PH_ADDR  = 3'd3,
    PH_DUMMY = 3'd4,
    PH_DATA  = 3'd5,
    PH_HOLD  = 3'd6,
    PH_GAP   = 3'd7
  } psq_phase_e;

  // cycles needed to move 'bits' when each cycle moves 'per_cycle' bits
  function automatic int unsigned psq_ceil_div(input int unsigned bits,
                                               input int unsigned per_cycle);
    return (bits + per_cycle - 1) / per_cycle;
  endfunction

  // two beats per clock on 'lines' wires
  function automatic int unsigned psq_bits_per_cycle(input int unsigned lines);
    return 2 * lines;
  endfunction

  function automatic int unsigned psq_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psq_phase_ctrl.sv
module psq_phase_ctrl
  import psq_pkg::*;
#(
  parameter int CNT_W         = 5,
  parameter int SETUP_CYC     = 4,
  parameter int HOLD_CYC      = 4,
  parameter int GAP_CYC       = 3,
  parameter int CMD_CYC       = 1,
  parameter int ADDR_CYC      = 2,
  parameter int CA_LINES      = 8,
  parameter int DQ_W          = 16,
  parameter int DUMMY_W       = 8,
  parameter int LEN_W         = 8,
  parameter int MAX_DATA_BITS = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [DUMMY_W-1:0] dummy_bits,
  input  logic [LEN_W-1:0]   data_bits,
  input  logic               is_write,
  input  logic               wide,
  output psq_phase_e         phase,
  output logic [CNT_W-1:0]   idx,
  output logic               accept,
  output logic               busy,
  output logic               done,
  output logic               cs_n,
  output logic               wr_q,
  output logic               wide_q
);

  logic [CNT_W-1:0] dum_q, dat_q;
  logic [CNT_W-1:0] dum_c, dat_c;
  logic [CNT_W-1:0] cur_len;
  logic             last;
  psq_phase_e       nxt;
  int unsigned      eff_bits;

  // lengths computed from the request at acceptance
  always_comb begin
    eff_bits = (32'(data_bits) > MAX_DATA_BITS) ? MAX_DATA_BITS : 32'(data_bits);
    dum_c    = CNT_W'(psq_ceil_div(32'(dummy_bits), psq_bits_per_cycle(CA_LINES)));
    dat_c    = CNT_W'(psq_ceil_div(eff_bits,
                                   psq_bits_per_cycle(wide ? DQ_W : DQ_W / 2)));
  end

  always_comb begin
    case (phase)
      PH_SETUP: cur_len = CNT_W'(SETUP_CYC);
      PH_CMD:   cur_len = CNT_W'(CMD_CYC);
      PH_ADDR:  cur_len = CNT_W'(ADDR_CYC);
      PH_DUMMY: cur_len = dum_q;
      PH_DATA:  cur_len = dat_q;
      PH_HOLD:  cur_len = CNT_W'(HOLD_CYC);
      PH_GAP:   cur_len = CNT_W'(GAP_CYC);
      default:  cur_len = '0;
    endcase
    last = (phase != PH_IDLE) && (idx == cur_len - 1'b1);
  end

  // next phase, skipping empty ones
  always_comb begin
    case (phase)
      PH_SETUP: nxt = PH_CMD;
      PH_CMD:   nxt = PH_ADDR;
      PH_ADDR:  nxt = (dum_q != '0) ? PH_DUMMY : ((dat_q != '0) ? PH_DATA : PH_HOLD);
      PH_DUMMY: nxt = (dat_q != '0) ? PH_DATA : PH_HOLD;
      PH_DATA:  nxt = PH_HOLD;
      PH_HOLD:  nxt = PH_GAP;
      default:  nxt = PH_IDLE;
    endcase
  end

  assign accept = (phase == PH_IDLE) && start;
  assign busy   = (phase != PH_IDLE);
  assign cs_n   = (phase == PH_IDLE) || (phase == PH_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      idx    <= '0;
      done   <= 1'b0;
      wr_q   <= 1'b0;
      wide_q <= 1'b0;
      dum_q  <= '0;
      dat_q  <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        phase  <= PH_SETUP;
        idx    <= '0;
        wr_q   <= is_write;
        wide_q <= wide;
        dum_q  <= dum_c;
        dat_q  <= dat_c;
      end else if (last) begin
        idx   <= '0;
        phase <= nxt;
        if (phase == PH_GAP) done <= 1'b1;
      end else if (phase != PH_IDLE) begin
        idx <= idx + 1'b1;
      end
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R10
  entry_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETUP && idx == '0) |-> ($past(phase) == PH_IDLE));
  // R11
  wide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(wide_q));

endmodule

// File: rtl/psq_tx_mux.sv
module psq_tx_mux
  import psq_pkg::*;
#(
  parameter int CNT_W         = 5,
  parameter int CMD_W         = 16,
  parameter int ADDR_W        = 32,
  parameter int CA_LINES      = 8,
  parameter int DQ_W          = 16,
  parameter int MAX_DATA_BITS = 128
) (
  input  psq_phase_e               phase,
  input  logic [CNT_W-1:0]         idx,
  input  logic [CMD_W-1:0]         cmd_q,
  input  logic [ADDR_W-1:0]        addr_q,
  input  logic [MAX_DATA_BITS-1:0] wdata_q,
  input  logic                     wr_q,
  input  logic                     wide_q,
  output logic [DQ_W-1:0]          dq_rise,
  output logic [DQ_W-1:0]          dq_fall,
  output logic                     dq_oe
);

  localparam int NARROW  = DQ_W / 2;
  localparam int CA_STEP = 2 * CA_LINES;
  localparam int PAD_W   = DQ_W - CA_LINES;

  logic [CMD_W-1:0]         cmd_sh;
  logic [ADDR_W-1:0]        addr_sh;
  logic [MAX_DATA_BITS-1:0] wr_sh;
  int unsigned              data_step;

  always_comb begin
    data_step = wide_q ? 2 * DQ_W : 2 * NARROW;
    cmd_sh    = cmd_q << (32'(idx) * CA_STEP);
    addr_sh   = addr_q << (32'(idx) * CA_STEP);
    wr_sh     = wdata_q >> (32'(idx) * data_step);
  end

  always_comb begin
    dq_rise = '0;
    dq_fall = '0;
    dq_oe   = 1'b0;
    case (phase)
      PH_CMD: begin
        dq_oe   = 1'b1;
        dq_rise = {{PAD_W{1'b0}}, cmd_sh[CMD_W-1 -: CA_LINES]};
        dq_fall = {{PAD_W{1'b0}}, cmd_sh[CMD_W-CA_LINES-1 -: CA_LINES]};
      end
      PH_ADDR: begin
        dq_oe   = 1'b1;
        dq_rise = {{PAD_W{1'b0}}, addr_sh[ADDR_W-1 -: CA_LINES]};
        dq_fall = {{PAD_W{1'b0}}, addr_sh[ADDR_W-CA_LINES-1 -: CA_LINES]};
      end
      PH_DUMMY: dq_oe = wr_q;
      PH_DATA: begin
        dq_oe = wr_q;
        if (wr_q) begin
          if (wide_q) begin
            dq_rise = wr_sh[DQ_W-1:0];
            dq_fall = wr_sh[2*DQ_W-1:DQ_W];
          end else begin
            dq_rise = {{NARROW{1'b0}}, wr_sh[NARROW-1:0]};
            dq_fall = {{NARROW{1'b0}}, wr_sh[DQ_W-1:NARROW]};
          end
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/psq_rx_capture.sv
module psq_rx_capture
  import psq_pkg::*;
#(
  parameter int CNT_W         = 5,
  parameter int DQ_W          = 16,
  parameter int MAX_DATA_BITS = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  psq_phase_e               phase,
  input  logic [CNT_W-1:0]         idx,
  input  logic                     wr_q,
  input  logic                     wide_q,
  input  logic [DQ_W-1:0]          dq_in_rise,
  input  logic [DQ_W-1:0]          dq_in_fall,
  output logic [MAX_DATA_BITS-1:0] rdata
);

  localparam int NARROW = DQ_W / 2;

  logic [DQ_W-1:0]          rise_m, fall_m;
  logic [MAX_DATA_BITS-1:0] merged;
  int unsigned              lanes, base;
  logic                     take;

  always_comb begin
    lanes  = wide_q ? DQ_W : NARROW;
    base   = 32'(idx) * 2 * lanes;
    rise_m = wide_q ? dq_in_rise : {{NARROW{1'b0}}, dq_in_rise[NARROW-1:0]};
    fall_m = wide_q ? dq_in_fall : {{NARROW{1'b0}}, dq_in_fall[NARROW-1:0]};
    take   = (phase == PH_DATA) && !wr_q;
    merged = rdata
           | (MAX_DATA_BITS'(rise_m) << base)
           | (MAX_DATA_BITS'(fall_m) << (base + lanes));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (clear) rdata <= '0;
    else if (take)  rdata <= merged;
  end

  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !clear) |=> $stable(rdata));

endmodule

// File: rtl/psram_phase_seq.sv
module psram_phase_seq
  import psq_pkg::*;
#(
  parameter int CMD_W         = 16,
  parameter int ADDR_W        = 32,
  parameter int CA_LINES      = 8,
  parameter int DQ_W          = 16,
  parameter int DUMMY_W       = 8,
  parameter int MAX_DATA_BITS = 128,
  parameter int SETUP_CYC     = 4,
  parameter int HOLD_CYC      = 4,
  parameter int GAP_CYC       = 3,
  localparam int LEN_W        = $clog2(MAX_DATA_BITS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_start,
  input  logic [CMD_W-1:0]         req_cmd,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DUMMY_W-1:0]       req_dummy_bits,
  input  logic                     req_write,
  input  logic [LEN_W-1:0]         req_data_bits,
  input  logic [MAX_DATA_BITS-1:0] req_wdata,
  input  logic                     cfg_wide,
  output logic                     busy,
  output logic                     done,
  output logic [MAX_DATA_BITS-1:0] rd_data,
  output logic                     mem_cs_n,
  output logic                     mem_dq_oe,
  output logic [DQ_W-1:0]          mem_dq_rise,
  output logic [DQ_W-1:0]          mem_dq_fall,
  input  logic [DQ_W-1:0]          mem_dq_in_rise,
  input  logic [DQ_W-1:0]          mem_dq_in_fall
);

  localparam int CMD_CYC  = int'(psq_ceil_div(CMD_W, psq_bits_per_cycle(CA_LINES)));
  localparam int ADDR_CYC = int'(psq_ceil_div(ADDR_W, psq_bits_per_cycle(CA_LINES)));
  localparam int DUM_MAX  = int'(psq_ceil_div((1 << DUMMY_W) - 1, psq_bits_per_cycle(CA_LINES)));
  localparam int DAT_MAX  = int'(psq_ceil_div(MAX_DATA_BITS, DQ_W));
  localparam int LONGEST  = int'(psq_max(psq_max(psq_max(SETUP_CYC, HOLD_CYC),
                                                 psq_max(GAP_CYC, ADDR_CYC)),
                                         psq_max(DUM_MAX, DAT_MAX)));
  localparam int CNT_W    = $clog2(LONGEST + 1);

  psq_phase_e               phase;
  logic [CNT_W-1:0]         idx;
  logic                     accept, wr_q, wide_q;
  logic [CMD_W-1:0]         cmd_q;
  logic [ADDR_W-1:0]        addr_q;
  logic [MAX_DATA_BITS-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      cmd_q   <= req_cmd;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  psq_phase_ctrl #(
    .CNT_W(CNT_W), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC), .GAP_CYC(GAP_CYC),
    .CMD_CYC(CMD_CYC), .ADDR_CYC(ADDR_CYC), .CA_LINES(CA_LINES), .DQ_W(DQ_W),
    .DUMMY_W(DUMMY_W), .LEN_W(LEN_W), .MAX_DATA_BITS(MAX_DATA_BITS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(req_start), .dummy_bits(req_dummy_bits),
    .data_bits(req_data_bits), .is_write(req_write), .wide(cfg_wide),
    .phase(phase), .idx(idx), .accept(accept), .busy(busy), .done(done),
    .cs_n(mem_cs_n), .wr_q(wr_q), .wide_q(wide_q)
  );

  psq_tx_mux #(
    .CNT_W(CNT_W), .CMD_W(CMD_W), .ADDR_W(ADDR_W), .CA_LINES(CA_LINES),
    .DQ_W(DQ_W), .MAX_DATA_BITS(MAX_DATA_BITS)
  ) u_tx (
    .phase(phase), .idx(idx), .cmd_q(cmd_q), .addr_q(addr_q), .wdata_q(wdata_q),
    .wr_q(wr_q), .wide_q(wide_q), .dq_rise(mem_dq_rise), .dq_fall(mem_dq_fall),
    .dq_oe(mem_dq_oe)
  );

  psq_rx_capture #(
    .CNT_W(CNT_W), .DQ_W(DQ_W), .MAX_DATA_BITS(MAX_DATA_BITS)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .clear(accept), .phase(phase), .idx(idx),
    .wr_q(wr_q), .wide_q(wide_q), .dq_in_rise(mem_dq_in_rise),
    .dq_in_fall(mem_dq_in_fall), .rdata(rd_data)
  );

  // R8
  oe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_cs_n);
  // R5
  read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_q && (phase == PH_DUMMY || phase == PH_DATA)) |-> !mem_dq_oe);

endmodule

// File: tb/test_psram_phase_seq.sv
module test_psram_phase_seq;

  localparam int CLK_PERIOD = 10;
  localparam int MAXB       = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0;
  logic [15:0] req_cmd = '0;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_dummy_bits = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_data_bits = '0;
  logic [MAXB-1:0] req_wdata = '0;
  logic        cfg_wide = 1'b0;
  logic        busy, done, mem_cs_n, mem_dq_oe;
  logic [MAXB-1:0] rd_data;
  logic [15:0] mem_dq_rise, mem_dq_fall;
  logic [15:0] mem_dq_in_rise = '0, mem_dq_in_fall = '0;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] rec_r [0:15];
  logic [15:0] rec_f [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  psram_phase_seq i_psram_phase_seq (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_dummy_bits(req_dummy_bits), .req_write(req_write),
    .req_data_bits(req_data_bits), .req_wdata(req_wdata), .cfg_wide(cfg_wide),
    .busy(busy), .done(done), .rd_data(rd_data), .mem_cs_n(mem_cs_n),
    .mem_dq_oe(mem_dq_oe), .mem_dq_rise(mem_dq_rise), .mem_dq_fall(mem_dq_fall),
    .mem_dq_in_rise(mem_dq_in_rise), .mem_dq_in_fall(mem_dq_in_fall)
  );

  function automatic int dum_cycles(input int bits);
    return (bits + 15) / 16;
  endfunction

  function automatic int dat_cycles(input int bits, input bit wide);
    int per = wide ? 32 : 16;
    int b   = (bits > MAXB) ? MAXB : bits;
    return (b + per - 1) / per;
  endfunction

  task automatic check(input bit ok, input string req, input logic [MAXB-1:0] act,
                       input logic [MAXB-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic run_txn(input logic [15:0] c, input logic [31:0] a, input int dmy,
                         input bit wr, input int bits, input logic [MAXB-1:0] wd,
                         input bit wd16, input bit noise);
    int d = dum_cycles(dmy);
    int n = dat_cycles(bits, wd16);
    int L = wd16 ? 16 : 8;
    int T = 14 + d + n;
    @(negedge clk);
    req_cmd = c; req_addr = a; req_dummy_bits = 8'(dmy); req_write = wr;
    req_data_bits = 8'(bits); req_wdata = wd; cfg_wide = wd16; req_start = 1'b1;
    for (int i = 0; i <= T + 1; i++) begin
      logic        e_cs, e_oe;
      logic [15:0] er, ef;
      logic [MAXB-1:0] e_rd;
      string       tag;
      int          j;
      @(negedge clk);
      e_cs = 1'b0; e_oe = 1'b0; er = '0; ef = '0; tag = "R8";
      if (i < 4) tag = "R2";
      else if (i == 4) begin
        tag = "R3"; e_oe = 1'b1; er = {8'h00, c[15:8]}; ef = {8'h00, c[7:0]};
      end else if (i < 7) begin
        tag = "R4"; e_oe = 1'b1;
        er = {8'h00, a[31-16*(i-5) -: 8]}; ef = {8'h00, a[23-16*(i-5) -: 8]};
      end else if (i < 7 + d) begin
        tag = "R5"; e_oe = wr;
      end else if (i < 7 + d + n) begin
        tag = "R6"; j = i - 7 - d;
        if (wr) begin
          e_oe = 1'b1;
          for (int k = 0; k < L; k++) begin
            int pr = 2 * j * L + k;
            int pf = (2 * j + 1) * L + k;
            er[k] = (pr < MAXB) ? wd[pr] : 1'b0;
            ef[k] = (pf < MAXB) ? wd[pf] : 1'b0;
          end
        end
      end else if (i < 11 + d + n) tag = "R8";
      else e_cs = 1'b1;
      check({mem_cs_n, mem_dq_oe, mem_dq_rise, mem_dq_fall} == {e_cs, e_oe, er, ef},
            tag, MAXB'({mem_cs_n, mem_dq_oe, mem_dq_rise, mem_dq_fall}),
            MAXB'({e_cs, e_oe, er, ef}));
      check(busy == (i < T), (i < T) ? "R8" : "R9", MAXB'(busy), MAXB'(i < T));
      check(done == (i == T), "R9", MAXB'(done), MAXB'(i == T));
      if (i == T) begin
        e_rd = '0;
        if (!wr) begin
          for (int p = 0; p < MAXB; p++) begin
            int beat = p / L;
            if (beat < 2 * n)
              e_rd[p] = (beat % 2) ? rec_f[beat/2][p % L] : rec_r[beat/2][p % L];
          end
        end
        check(rd_data == e_rd, "R7", rd_data, e_rd);
      end
      mem_dq_in_rise = 16'($urandom);
      mem_dq_in_fall = 16'($urandom);
      if (i >= 7 + d && i < 7 + d + n) begin
        rec_r[i-7-d] = mem_dq_in_rise;
        rec_f[i-7-d] = mem_dq_in_fall;
      end
      if (noise && i < T) begin
        // R10 / R11 disturbances while busy
        req_start = 1'($urandom);
        req_cmd = 16'($urandom); req_addr = $urandom; req_write = 1'($urandom);
        req_dummy_bits = 8'($urandom); req_data_bits = 8'($urandom % 129);
        req_wdata = {$urandom, $urandom, $urandom, $urandom}; cfg_wide = 1'($urandom);
      end else req_start = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1 reset state
    check({mem_cs_n, busy, done, mem_dq_oe} == 4'b1000, "R1",
          MAXB'({mem_cs_n, busy, done, mem_dq_oe}), MAXB'(4'b1000));
    check(rd_data == '0, "R1", rd_data, '0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run_txn(16'h0000, 32'h1234_5678, 18, 1'b0, 64,  '0, 1'b1, 1'b0);
    run_txn(16'h8080, 32'hA5C3_0F11, 8,  1'b1, 32,
            128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1'b0, 1'b0);
    run_txn(16'hC0C0, 32'h0000_0008, 0,  1'b1, 16, 128'hBEEF, 1'b1, 1'b0);
    run_txn(16'h4040, 32'h0000_0002, 18, 1'b0, 8,   '0, 1'b0, 1'b0);
    run_txn(16'h2020, 32'hFFFF_FFFF, 18, 1'b0, 0,   '0, 1'b1, 1'b1);
    run_txn(16'hA0A0, 32'h8000_0001, 8,  1'b1, 128,
            {$urandom, $urandom, $urandom, $urandom}, 1'b0, 1'b1);
    run_txn(16'h2020, 32'h0BAD_F00D, 18, 1'b0, 128, '0, 1'b0, 1'b1);
    run_txn(16'h2020, 32'h0BAD_F00D, 18, 1'b0, 120, '0, 1'b1, 1'b1);
    // random mix
    for (int t = 0; t < 40; t++) begin
      int   sel = int'($urandom % 6);
      logic [15:0] c;
      int   dm;
      bit   w;
      case (sel)
        0: begin c = 16'h0000; dm = 18; w = 1'b0; end
        1: begin c = 16'h8080; dm = 8;  w = 1'b1; end
        2: begin c = 16'h2020; dm = 18; w = 1'b0; end
        3: begin c = 16'hA0A0; dm = 8;  w = 1'b1; end
        4: begin c = 16'h4040; dm = 18; w = 1'b0; end
        default: begin c = 16'hC0C0; dm = 0; w = 1'b1; end
      endcase
      run_txn(c, $urandom, dm, w, int'($urandom % 129),
              {$urandom, $urandom, $urandom, $urandom}, 1'($urandom), 1'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule